// File: doc/BRIEF.md
# Privilege-Aware Interrupt Pending Arbiter

This block holds the pending state for seven interrupt sources. Each source has a 64-bit pending vector and a one-bit summary flag. Producers post or retire single bits: a request names a source number and a bit index. The block reads the current hypervisor-privilege and interrupt-enable flags. From these and the summary flags it selects the one interrupt that a core should take next, and it presents a 3-bit trap code with a valid flag.

The priority order depends on the privilege mode. In hypervisor mode only the tick-match and vector sources are eligible, and only while interrupts are enabled. In normal mode three urgent sources are taken regardless of the enable flag, and four further sources require it. When the soft-interrupt source wins, the block also reports a 4-bit level derived from that source's vector. A global pending flag and a combinational read port for any source's vector complete the interface.

Source numbers: 0 tick match, 1 interrupt vector, 2 trap-level-zero, 3 CPU mondo, 4 device mondo, 5 soft interrupt, 6 resumable error; 7 is not a valid source.

Top module: `intr_arbiter`

## Requirements
- R1: A post to source s (0..6) with index i sets bit i of that source's vector from the next clock edge. `rd_vec` shows the vector of source `rd_type` combinationally, and it is zero when `rd_type` is 7.
- R2: A clear resets bit i of source s. The source stays pending, and `any_pend` stays high, while any other bit of that vector is still set.
- R3: When a post and a clear name the same source and index in one cycle, the bit ends up set.
- R4: `any_pend` is high exactly when some vector is non-zero, whatever the values of `hpriv` and `ie`.
- R5: While `hpriv` is 1, no trap is selected unless `ie` is 1. When enabled, tick match (code 2) beats interrupt vector (code 3), and no other source is selected.
- R6: While `hpriv` is 0, the order is trap-level-zero (code 1), tick match (2), vector (3), regardless of `ie`. These are followed, only when `ie` is 1, by CPU mondo (4), device mondo (5), soft interrupt (6) and resumable error (7). Code 0 means none.
- R7: When soft interrupt is selected and bit 0 or bit 16 of its vector is set, `soft_lvl` is 14.
- R8: Otherwise, when soft interrupt is selected, `soft_lvl` is the index of the highest set bit among bits 15..1, or 0 if none of them is set. When soft interrupt is not selected, `soft_lvl` is 0.
- R9: Reset and `clr_all` zero every vector and summary flag. `clr_all` overrides a post or clear issued in the same cycle.
- R10: A post or clear that names source 7 changes no state. It raises `req_err` for exactly the one cycle after the request edge.
- R11: `trap_vld` is 1 exactly when `trap_code` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Post request strobe |
| post_type | input | 3 | Source number of the post |
| post_idx | input | 6 | Bit index of the post |
| clr_vld | input | 1 | Clear request strobe |
| clr_type | input | 3 | Source number of the clear |
| clr_idx | input | 6 | Bit index of the clear |
| clr_all | input | 1 | Zero all pending state |
| hpriv | input | 1 | Hypervisor-privilege mode flag |
| ie | input | 1 | Interrupt-enable flag |
| rd_type | input | 3 | Source selected for the read port |
| rd_vec | output | 64 | Pending vector of the selected source |
| any_pend | output | 1 | Some source is pending |
| trap_vld | output | 1 | A trap is selected |
| trap_code | output | 3 | Identity of the selected trap |
| soft_lvl | output | 4 | Soft-interrupt level when code 6 is selected |
| req_err | output | 1 | One-cycle pulse after an invalid source number |

## Verification
State changes land at the clock edge that samples a request. `rd_vec`, `any_pend`, `trap_code`, `trap_vld` and `soft_lvl` are combinational from that state and from the current `hpriv`, `ie` and `rd_type`, so they are due in the same cycle that follows the edge. `req_err` is registered, so it is due in that cycle as well, and it is gone one edge later. The bench drives inputs on the falling edge and updates its model at the rising edge. It compares every output at the next falling edge, before it drives new inputs, so each comparison pairs the post-edge state with the mode flags that are being applied.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;

    localparam int NUM_SRC = 7;
    localparam int VEC_W   = 64;
    localparam int TYPE_W  = 3;
    localparam int IDX_W   = $clog2(VEC_W);
    localparam int CODE_W  = 3;
    localparam int LVL_W   = 4;
    localparam int SOFT_W  = 17;

    typedef enum logic [TYPE_W-1:0] {
        SRC_TICK = 3'd0,
        SRC_VEC  = 3'd1,
        SRC_TLZ  = 3'd2,
        SRC_CPU  = 3'd3,
        SRC_DEV  = 3'd4,
        SRC_SOFT = 3'd5,
        SRC_RERR = 3'd6
    } src_e;

    typedef enum logic [CODE_W-1:0] {
        TC_NONE = 3'd0,
        TC_TLZ  = 3'd1,
        TC_TICK = 3'd2,
        TC_VEC  = 3'd3,
        TC_CPU  = 3'd4,
        TC_DEV  = 3'd5,
        TC_SOFT = 3'd6,
        TC_RERR = 3'd7
    } tcode_e;

    typedef struct packed {
        logic              vld;
        logic [TYPE_W-1:0] typ;
        logic [IDX_W-1:0]  idx;
    } bit_req_t;

    // Level encoding of the soft-interrupt vector: two forcing bits
    // map to 14, otherwise the highest of bits 15..1 wins.
    function automatic logic [LVL_W-1:0] soft_level(input logic [SOFT_W-1:0] s);
        logic [LVL_W-1:0] l;
        l = '0;
        for (int i = 1; i < 16; i++) begin
            if (s[i]) l = LVL_W'(i);
        end
        if (s[0] || s[16]) l = LVL_W'(14);
        return l;
    endfunction

endpackage

// File: rtl/intr_pend_bank.sv
module intr_pend_bank
    import intr_arb_pkg::*;
#(
    parameter int NS = NUM_SRC,
    parameter int VW = VEC_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr_all,
    input  bit_req_t               post,
    input  bit_req_t               clr,
    output logic [NS-1:0][VW-1:0]  vec,
    output logic [NS-1:0]          stat,
    output logic                   err
);
    localparam logic [TYPE_W-1:0] LIMIT = TYPE_W'(NS);

    logic bad_req;
    assign bad_req = (post.vld && (post.typ >= LIMIT)) ||
                     (clr.vld  && (clr.typ  >= LIMIT));

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= bad_req;
    end

    for (genvar g = 0; g < NS; g++) begin : g_slot
        logic [VW-1:0] set_m;
        logic [VW-1:0] clr_m;
        logic [VW-1:0] nxt;
        logic [VW-1:0] v_q;
        logic          s_q;

        assign set_m = (post.vld && post.typ == TYPE_W'(g)) ? (VW'(1) << post.idx) : '0;
        assign clr_m = (clr.vld  && clr.typ  == TYPE_W'(g)) ? (VW'(1) << clr.idx)  : '0;
        // set mask applied after clear mask: post wins on collision
        assign nxt   = (v_q & ~clr_m) | set_m;

        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                v_q <= '0;
                s_q <= 1'b0;
            end else begin
                v_q <= nxt;
                if (|set_m)
                    s_q <= 1'b1;
                else if ((|clr_m) && (nxt == '0))
                    s_q <= 1'b0;
            end
        end

        assign vec[g]  = v_q;
        assign stat[g] = s_q;
    end

endmodule

// File: rtl/intr_prio_sel.sv
module intr_prio_sel
    import intr_arb_pkg::*;
(
    input  logic [NUM_SRC-1:0] stat,
    input  logic               hpriv,
    input  logic               ie,
    output tcode_e             code
);
    always_comb begin
        code = TC_NONE;
        if (hpriv) begin
            if (ie) begin
                if      (stat[SRC_TICK]) code = TC_TICK;
                else if (stat[SRC_VEC])  code = TC_VEC;
            end
        end else begin
            if      (stat[SRC_TLZ])          code = TC_TLZ;
            else if (stat[SRC_TICK])         code = TC_TICK;
            else if (stat[SRC_VEC])          code = TC_VEC;
            else if (ie && stat[SRC_CPU])    code = TC_CPU;
            else if (ie && stat[SRC_DEV])    code = TC_DEV;
            else if (ie && stat[SRC_SOFT])   code = TC_SOFT;
            else if (ie && stat[SRC_RERR])   code = TC_RERR;
        end
    end
endmodule

// File: rtl/intr_soft_lvl.sv
module intr_soft_lvl
    import intr_arb_pkg::*;
(
    input  logic [SOFT_W-1:0] soft_bits,
    input  logic              sel,
    output logic [LVL_W-1:0]  lvl
);
    always_comb begin
        lvl = sel ? soft_level(soft_bits) : '0;
    end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
    import intr_arb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 post_vld,
    input  logic [TYPE_W-1:0]    post_type,
    input  logic [IDX_W-1:0]     post_idx,
    input  logic                 clr_vld,
    input  logic [TYPE_W-1:0]    clr_type,
    input  logic [IDX_W-1:0]     clr_idx,
    input  logic                 clr_all,
    input  logic                 hpriv,
    input  logic                 ie,
    input  logic [TYPE_W-1:0]    rd_type,
    output logic [VEC_W-1:0]     rd_vec,
    output logic                 any_pend,
    output logic                 trap_vld,
    output logic [CODE_W-1:0]    trap_code,
    output logic [LVL_W-1:0]     soft_lvl,
    output logic                 req_err
);
    localparam logic [TYPE_W-1:0] LIMIT = TYPE_W'(NUM_SRC);

    bit_req_t                        post_r;
    bit_req_t                        clr_r;
    logic [NUM_SRC-1:0][VEC_W-1:0]   vec;
    logic [NUM_SRC-1:0]              stat;
    tcode_e                          code;

    assign post_r = '{vld: post_vld, typ: post_type, idx: post_idx};
    assign clr_r  = '{vld: clr_vld,  typ: clr_type,  idx: clr_idx};

    intr_pend_bank #(.NS(NUM_SRC), .VW(VEC_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .clr_all (clr_all),
        .post    (post_r),
        .clr     (clr_r),
        .vec     (vec),
        .stat    (stat),
        .err     (req_err)
    );

    intr_prio_sel u_sel (
        .stat  (stat),
        .hpriv (hpriv),
        .ie    (ie),
        .code  (code)
    );

    intr_soft_lvl u_lvl (
        .soft_bits (vec[SRC_SOFT][SOFT_W-1:0]),
        .sel       (code == TC_SOFT),
        .lvl       (soft_lvl)
    );

    always_comb begin
        rd_vec = '0;
        if (rd_type < LIMIT) rd_vec = vec[rd_type];
    end

    assign any_pend  = |stat;
    assign trap_code = code;
    assign trap_vld  = (code != TC_NONE);

endmodule

// File: rtl/intr_arbiter_chk.sv
module intr_arbiter_chk
    import intr_arb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              post_vld,
    input logic [TYPE_W-1:0] post_type,
    input logic              clr_vld,
    input logic [TYPE_W-1:0] clr_type,
    input logic              clr_all,
    input logic              hpriv,
    input logic              ie,
    input logic              any_pend,
    input logic              trap_vld,
    input logic [CODE_W-1:0] trap_code,
    input logic [LVL_W-1:0]  soft_lvl,
    input logic              req_err
);
    logic bad_now;
    assign bad_now = (post_vld && post_type == 3'd7) || (clr_vld && clr_type == 3'd7);

    assert_err_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (req_err == $past(bad_now)));

    assert_hpriv_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (hpriv && !ie) |-> !trap_vld);

    assert_hpriv_codes_R5: assert property (@(posedge clk) disable iff (rst)
        (hpriv && trap_vld) |-> (trap_code == 3'd2 || trap_code == 3'd3));

    assert_sel_needs_pend_R4: assert property (@(posedge clk) disable iff (rst)
        trap_vld |-> any_pend);

    assert_post_pends_R1: assert property (@(posedge clk) disable iff (rst)
        (post_vld && post_type != 3'd7 && !clr_all) |=> any_pend);

    assert_clr_all_R9: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> !any_pend);

    assert_lvl_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (trap_code != 3'd6) |-> (soft_lvl == 4'd0));

    assert_gated_low_R6: assert property (@(posedge clk) disable iff (rst)
        (!hpriv && !ie) |-> (trap_code <= 3'd3));
endmodule

bind intr_arbiter intr_arbiter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .post_vld  (post_vld),
    .post_type (post_type),
    .clr_vld   (clr_vld),
    .clr_type  (clr_type),
    .clr_all   (clr_all),
    .hpriv     (hpriv),
    .ie        (ie),
    .any_pend  (any_pend),
    .trap_vld  (trap_vld),
    .trap_code (trap_code),
    .soft_lvl  (soft_lvl),
    .req_err   (req_err)
);

// File: tb/intr_arbiter_tb.sv
module intr_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        post_vld = 0, clr_vld = 0, clr_all = 0, hpriv = 0, ie = 0;
    logic [2:0]  post_type = 0, clr_type = 0, rd_type = 0;
    logic [5:0]  post_idx = 0, clr_idx = 0;
    logic [63:0] rd_vec;
    logic        any_pend, trap_vld, req_err;
    logic [2:0]  trap_code;
    logic [3:0]  soft_lvl;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] mv [7];
    logic        m_err = 0;

    always #4 clk = ~clk;

    intr_arbiter u_dut (
        .clk(clk), .rst(rst),
        .post_vld(post_vld), .post_type(post_type), .post_idx(post_idx),
        .clr_vld(clr_vld), .clr_type(clr_type), .clr_idx(clr_idx),
        .clr_all(clr_all), .hpriv(hpriv), .ie(ie), .rd_type(rd_type),
        .rd_vec(rd_vec), .any_pend(any_pend), .trap_vld(trap_vld),
        .trap_code(trap_code), .soft_lvl(soft_lvl), .req_err(req_err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_code(input logic hp, input logic en);
        if (hp) begin
            if (!en) return 3'd0;
            if (mv[0] != 0) return 3'd2;
            if (mv[1] != 0) return 3'd3;
            return 3'd0;
        end
        if (mv[2] != 0) return 3'd1;
        if (mv[0] != 0) return 3'd2;
        if (mv[1] != 0) return 3'd3;
        if (!en) return 3'd0;
        if (mv[3] != 0) return 3'd4;
        if (mv[4] != 0) return 3'd5;
        if (mv[5] != 0) return 3'd6;
        if (mv[6] != 0) return 3'd7;
        return 3'd0;
    endfunction

    function automatic logic [3:0] exp_lvl(input logic [63:0] s);
        if (s[0] || s[16]) return 4'd14;
        for (int i = 15; i >= 1; i--) if (s[i]) return 4'(i);
        return 4'd0;
    endfunction

    function automatic logic any_model();
        for (int t = 0; t < 7; t++) if (mv[t] != 0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check_all();
        logic [2:0] c;
        logic [63:0] rv;
        c  = exp_code(hpriv, ie);
        rv = (rd_type == 3'd7) ? 64'd0 : mv[rd_type];
        chk("R1", "rd_vec", rd_vec, rv);
        chk("R4", "any_pend", {63'd0, any_pend}, {63'd0, any_model()});
        chk(hpriv ? "R5" : "R6", "trap_code", {61'd0, trap_code}, {61'd0, c});
        chk("R11", "trap_vld", {63'd0, trap_vld}, {63'd0, c != 3'd0});
        if (c == 3'd6 && (mv[5][0] || mv[5][16]))
            chk("R7", "soft_lvl", {60'd0, soft_lvl}, 64'd14);
        else
            chk("R8", "soft_lvl", {60'd0, soft_lvl},
                {60'd0, (c == 3'd6) ? exp_lvl(mv[5]) : 4'd0});
        chk("R10", "req_err", {63'd0, req_err}, {63'd0, m_err});
    endtask

    task automatic step(input logic pv, input logic [2:0] pt, input logic [5:0] pi,
                        input logic cv, input logic [2:0] ct, input logic [5:0] ci,
                        input logic ca, input logic hp, input logic en,
                        input logic [2:0] rt);
        post_vld = pv; post_type = pt; post_idx = pi;
        clr_vld = cv; clr_type = ct; clr_idx = ci;
        clr_all = ca; hpriv = hp; ie = en; rd_type = rt;
        @(posedge clk);
        m_err = (pv && pt == 3'd7) || (cv && ct == 3'd7);
        if (ca) begin
            for (int t = 0; t < 7; t++) mv[t] = 64'd0;
        end else begin
            if (cv && ct != 3'd7) mv[ct][ci] = 1'b0;
            if (pv && pt != 3'd7) mv[pt][pi] = 1'b1;
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic idle(input logic hp, input logic en, input logic [2:0] rt);
        step(0, 0, 0, 0, 0, 0, 0, hp, en, rt);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int t = 0; t < 7; t++) mv[t] = 64'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state, R9
        chk("R9", "reset any_pend", {63'd0, any_pend}, 64'd0);
        chk("R9", "reset code", {61'd0, trap_code}, 64'd0);
        check_all();

        // soft level forcing bits (R7) and highest-bit encoding (R8)
        step(1, 5, 16, 0, 0, 0, 0, 0, 1, 5);
        step(1, 5, 9, 1, 5, 16, 0, 0, 1, 5);
        step(1, 5, 3, 0, 0, 0, 0, 0, 1, 5);
        chk("R8", "lvl highest", {60'd0, soft_lvl}, 64'd9);
        step(1, 5, 0, 0, 0, 0, 0, 0, 1, 5);
        chk("R7", "lvl bit0", {60'd0, soft_lvl}, 64'd14);
        step(0, 0, 0, 1, 5, 0, 0, 0, 0, 5);
        chk("R6", "soft gated by ie", {61'd0, trap_code}, 64'd0);
        chk("R4", "pend without ie", {63'd0, any_pend}, 64'd1);
        step(1, 5, 40, 1, 5, 9, 0, 0, 1, 5);
        step(0, 0, 0, 1, 5, 3, 0, 0, 1, 5);
        chk("R8", "lvl none in 1..15", {60'd0, soft_lvl}, 64'd0);
        chk("R2", "still pending", {63'd0, any_pend}, 64'd1);
        step(0, 0, 0, 1, 5, 40, 0, 0, 1, 5);
        chk("R2", "vector empty", {63'd0, any_pend}, 64'd0);

        // privilege ordering R5/R6
        step(1, 2, 7, 0, 0, 0, 0, 0, 0, 2);
        chk("R6", "tlz ignores ie", {61'd0, trap_code}, 64'd1);
        step(1, 1, 1, 0, 0, 0, 0, 1, 0, 1);
        chk("R5", "hpriv gated", {61'd0, trap_code}, 64'd0);
        step(1, 0, 63, 0, 0, 0, 0, 1, 1, 0);
        chk("R5", "tick over vec", {61'd0, trap_code}, 64'd2);

        // post wins on same index R3
        step(1, 3, 12, 1, 3, 12, 0, 0, 1, 3);
        chk("R3", "post wins", rd_vec, 64'h1000);

        // invalid source R10
        step(1, 7, 5, 1, 7, 5, 0, 0, 1, 7);
        chk("R10", "err pulse", {63'd0, req_err}, 64'd1);
        chk("R1", "rd type 7", rd_vec, 64'd0);
        idle(0, 1, 3);
        chk("R10", "err drops", {63'd0, req_err}, 64'd0);

        // clr_all beats post R9
        step(1, 4, 4, 0, 0, 0, 1, 0, 1, 4);
        chk("R9", "clr_all wins", {63'd0, any_pend}, 64'd0);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [5:0] pi, ci;
            logic [2:0] pt, ct;
            pi = ($urandom % 2) ? 6'($urandom % 20) : 6'($urandom % 64);
            pt = 3'($urandom % 8);
            ct = ($urandom % 3 == 0) ? pt : 3'($urandom % 8);
            ci = ($urandom % 3 == 0) ? pi : 6'($urandom % 20);
            step(1'($urandom % 2), pt, pi, 1'($urandom % 2), ct, ci,
                 ($urandom % 60) == 0, 1'($urandom % 2), 1'($urandom % 2),
                 3'($urandom % 8));
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule